// File: doc/BRIEF.md
# Range-Matched Translation Buffer with Age-Rank Replacement

This block is a small, fully associative cache of address translations. Each slot holds a virtual start address, a physical base, a span code that selects one of three power-of-two region sizes, and user, writable and global attributes. A lookup compares the request address against every valid slot in the same cycle. On a hit it returns the physical address and a permission verdict. A page-table walker sits outside the block and fills slots through the insert port. Operating-system maintenance reaches the block through a two-bit command that empties every slot, empties only the non-global slots, or removes the one slot that covers a given address.

Replacement is least-recently-used. Every slot carries an age rank, and the ranks form a permutation of 0..ENTRIES-1, with 0 the most recent. An insert first takes a free slot. When none is free, it takes the valid slot whose rank is the oldest. A lookup can ask for its hit slot to be promoted to most recent. Demap and plain lookups leave the ranks alone.

Top module: `xlate_buf`

## Requirements
- R1: After reset no slot is valid and every lookup misses. A lookup address `va` hits a valid slot when `start <= va < start + span`. The comparison is done at one bit wider than the address, so a region that ends at the top of the address space still matches.
- R2: On a hit, `lk_pa` equals the slot's physical base OR'd with `va & (span - 1)`. On a miss `lk_pa` is zero.
- R3: Span code 0 selects 4 KiB, code 1 selects 2 MiB and code 2 selects 1 GiB. Code 3 is treated as 4 KiB. Insert address bits below the span are dropped from both the stored start and the stored physical base.
- R4: An access is a user access when `lk_cpl` is 3 and `lk_force_sup` is 0. A user access that hits a slot without the user attribute raises `lk_fault`, with `lk_fault_user` set to 1.
- R5: Access mode encoding is 00 read, 01 write and 10 execute. A write that hits a non-writable slot faults with `lk_fault_wr` set to 1. Read and execute accesses never fault on the writable attribute alone.
- R6: When `lk_store_chk` is 1, a hit on a non-writable slot faults and is reported as a write (`lk_fault_wr` = 1), whatever the mode.
- R7: A miss never raises `lk_fault`, `lk_fault_wr` or `lk_fault_user`. With no fault, both detail outputs are 0.
- R8: An insert occupies a free slot while one exists, so no valid translation is lost until all ENTRIES slots are valid.
- R9: When all slots are valid, an insert replaces the least recently used slot. The inserted slot becomes most recent. A hit with `lk_promote` set also becomes most recent.
- R10: A lookup with `lk_promote` clear, a miss, and a demap all leave the recency order unchanged.
- R11: Maintenance encoding is 00 none, 01 invalidate all, 10 invalidate the slots whose global attribute is clear, and 11 demap the single slot that covers `mnt_va`.
- R12: A maintenance command suppresses an insert and a promotion presented in the same cycle. An insert suppresses a promotion presented in the same cycle.
- R13: Lookup outputs are combinational in the current cycle. Insert, promotion and maintenance take effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | ADDR_W | Lookup virtual address |
| lk_mode | input | 2 | Access mode (00 read, 01 write, 10 execute) |
| lk_cpl | input | 2 | Current privilege level |
| lk_force_sup | input | 1 | Treat the access as supervisor |
| lk_store_chk | input | 1 | Probe write permission |
| lk_promote | input | 1 | Make the hit slot most recent |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | ADDR_W | Translated physical address |
| lk_fault | output | 1 | Permission fault |
| lk_fault_wr | output | 1 | Faulting access is reported as a write |
| lk_fault_user | output | 1 | Faulting access was a user access |
| ins_en | input | 1 | Insert a translation |
| ins_va | input | ADDR_W | Insert virtual start |
| ins_pa | input | ADDR_W | Insert physical base |
| ins_span | input | 2 | Span code |
| ins_user | input | 1 | User accessible |
| ins_wr | input | 1 | Writable |
| ins_glb | input | 1 | Global |
| mnt_op | input | 2 | Maintenance command |
| mnt_va | input | ADDR_W | Demap address |

## Verification
Several pairs of functions can land on the same clock edge: an insert together with a promoting lookup, a maintenance command together with an insert, and a demap together with a promotion. The bench presents each pair in one cycle, both in directed sequences and throughout a long random phase. It then judges the result through later lookups. A behavioural queue model says which translations must survive, and which one the next eviction on a full buffer must remove. A promotion that was wrongly applied or wrongly dropped shows up as a different eviction victim, which appears in the hit pattern some cycles later.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10
  } acc_e;

  typedef enum logic [1:0] {
    MNT_NONE        = 2'b00,
    MNT_FLUSH_ALL   = 2'b01,
    MNT_FLUSH_LOCAL = 2'b10,
    MNT_DEMAP       = 2'b11
  } mnt_e;

  // Number of offset bits spanned by a region of the given code.
  function automatic int unsigned span_shift(input logic [1:0] code);
    case (code)
      2'd1:    span_shift = 21;
      2'd2:    span_shift = 30;
      default: span_shift = 12;
    endcase
  endfunction

endpackage

// File: rtl/xlate_match.sv
module xlate_match
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] start,
  input  logic [ENTRIES-1:0][1:0]        span,
  input  logic [ADDR_W-1:0]              va,
  output logic [ENTRIES-1:0]             hit_vec,
  output logic                           any_hit,
  output logic [IW-1:0]                  hit_idx
);

  // One range comparator per slot, one bit wider than the address.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [ADDR_W-1:0] msk;
    logic [ADDR_W:0]   lo, hi, v;
    always_comb begin
      msk = ADDR_W'((64'd1 << span_shift(span[g])) - 64'd1);
      lo  = {1'b0, start[g]};
      hi  = lo + {1'b0, msk} + (ADDR_W+1)'(1);
      v   = {1'b0, va};
      hit_vec[g] = valid[g] && (lo <= v) && (v < hi);
    end
  end

  // Lowest index wins.
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/xlate_age.sv
module xlate_age #(
  parameter int ENTRIES = 8,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_en,
  input  logic [IW-1:0]      upd_idx,
  input  logic [ENTRIES-1:0] free_vec,
  output logic [IW-1:0]      victim_idx
);

  localparam logic [IW-1:0] OLDEST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0][IW-1:0] age_q, age_d;
  logic [IW-1:0]              sel_age;

  assign sel_age = age_q[upd_idx];

  // Next-state: touched slot goes to rank 0, younger slots age by one.
  always_comb begin
    age_d = age_q;
    if (upd_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IW'(i) == upd_idx)       age_d[i] = '0;
        else if (age_q[i] < sel_age) age_d[i] = age_q[i] + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IW'(i);
    end else if (upd_en) begin
      age_q <= age_d;
    end
  end

  // Victim: lowest free slot, else the oldest rank.
  always_comb begin
    victim_idx = '0;
    if (|free_vec) begin
      for (int i = ENTRIES - 1; i >= 0; i--) begin
        if (free_vec[i]) victim_idx = IW'(i);
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (age_q[i] == OLDEST) victim_idx = IW'(i);
      end
    end
  end

  for (genvar k = 0; k < ENTRIES; k++) begin : g_rank_chk
    logic [ENTRIES-1:0] owns;
    always_comb begin
      for (int i = 0; i < ENTRIES; i++) owns[i] = (age_q[i] == IW'(k));
    end
    AST_AGE_RANK_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(owns) == 1); // R9
  end

  AST_AGE_TOUCH_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> age_q[$past(upd_idx)] == '0); // R9

  AST_AGE_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(age_q)); // R10

  AST_VICTIM_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (|free_vec) |-> free_vec[victim_idx]); // R8

endmodule

// File: rtl/xlate_perm.sv
module xlate_perm
  import xlate_pkg::*;
(
  input  logic       hit,
  input  logic [1:0] mode,
  input  logic [1:0] cpl,
  input  logic       force_sup,
  input  logic       store_chk,
  input  logic       ent_user,
  input  logic       ent_wr,
  output logic       fault,
  output logic       fault_wr,
  output logic       fault_user
);

  logic is_user, wants_wr, user_bad, wr_bad;

  always_comb begin
    is_user    = (cpl == 2'd3) && !force_sup;
    wants_wr   = (mode == ACC_WRITE) || store_chk;
    user_bad   = is_user && !ent_user;
    wr_bad     = wants_wr && !ent_wr;
    fault      = hit && (user_bad || wr_bad);
    fault_wr   = fault && wants_wr;
    fault_user = fault && is_user;
  end

endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_va,
  input  logic [1:0]        lk_mode,
  input  logic [1:0]        lk_cpl,
  input  logic              lk_force_sup,
  input  logic              lk_store_chk,
  input  logic              lk_promote,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_pa,
  output logic              lk_fault,
  output logic              lk_fault_wr,
  output logic              lk_fault_user,
  input  logic              ins_en,
  input  logic [ADDR_W-1:0] ins_va,
  input  logic [ADDR_W-1:0] ins_pa,
  input  logic [1:0]        ins_span,
  input  logic              ins_user,
  input  logic              ins_wr,
  input  logic              ins_glb,
  input  logic [1:0]        mnt_op,
  input  logic [ADDR_W-1:0] mnt_va
);

  localparam int IW = $clog2(ENTRIES);

  // Slot storage
  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0][ADDR_W-1:0] start_q, start_d;
  logic [ENTRIES-1:0][ADDR_W-1:0] pbase_q, pbase_d;
  logic [ENTRIES-1:0][1:0]        span_q, span_d;
  logic [ENTRIES-1:0]             user_q, user_d;
  logic [ENTRIES-1:0]             wr_q, wr_d;
  logic [ENTRIES-1:0]             glb_q, glb_d;
  logic                           slot_we;

  // Two range matchers: lookup port and demap port.
  logic [1:0][ADDR_W-1:0]  probe_va;
  logic [1:0][ENTRIES-1:0] probe_vec;
  logic [1:0]              probe_any;
  logic [1:0][IW-1:0]      probe_idx;

  assign probe_va[0] = lk_va;
  assign probe_va[1] = mnt_va;

  for (genvar p = 0; p < 2; p++) begin : g_probe
    xlate_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
      .valid   (valid_q),
      .start   (start_q),
      .span    (span_q),
      .va      (probe_va[p]),
      .hit_vec (probe_vec[p]),
      .any_hit (probe_any[p]),
      .hit_idx (probe_idx[p])
    );
  end

  // Lookup data path
  logic [IW-1:0]     sel;
  logic [ADDR_W-1:0] sel_mask;

  assign sel      = probe_idx[0];
  assign sel_mask = ADDR_W'((64'd1 << span_shift(span_q[sel])) - 64'd1);
  assign lk_hit   = probe_any[0];
  assign lk_pa    = probe_any[0] ? (pbase_q[sel] | (lk_va & sel_mask)) : '0;

  xlate_perm u_perm (
    .hit        (probe_any[0]),
    .mode       (lk_mode),
    .cpl        (lk_cpl),
    .force_sup  (lk_force_sup),
    .store_chk  (lk_store_chk),
    .ent_user   (user_q[sel]),
    .ent_wr     (wr_q[sel]),
    .fault      (lk_fault),
    .fault_wr   (lk_fault_wr),
    .fault_user (lk_fault_user)
  );

  // Arbitration: maintenance > insert > promotion
  logic          mnt_busy, ins_do, pro_do;
  logic [IW-1:0] victim;
  logic [ADDR_W-1:0] ins_mask;

  assign mnt_busy = (mnt_op != MNT_NONE);
  assign ins_do   = ins_en && !mnt_busy;
  assign pro_do   = lk_promote && probe_any[0] && !mnt_busy && !ins_en;
  assign ins_mask = ADDR_W'((64'd1 << span_shift(ins_span)) - 64'd1);

  xlate_age #(.ENTRIES(ENTRIES)) u_age (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (ins_do || pro_do),
    .upd_idx    (ins_do ? victim : sel),
    .free_vec   (~valid_q),
    .victim_idx (victim)
  );

  // Next-state for slot storage
  always_comb begin
    valid_d = valid_q;
    start_d = start_q;
    pbase_d = pbase_q;
    span_d  = span_q;
    user_d  = user_q;
    wr_d    = wr_q;
    glb_d   = glb_q;
    slot_we = 1'b0;
    case (mnt_op)
      MNT_FLUSH_ALL:   valid_d = '0;
      MNT_FLUSH_LOCAL: valid_d = valid_q & glb_q;
      MNT_DEMAP:       if (probe_any[1]) valid_d[probe_idx[1]] = 1'b0;
      default: ;
    endcase
    if (ins_do) begin
      slot_we         = 1'b1;
      valid_d[victim] = 1'b1;
      start_d[victim] = ins_va & ~ins_mask;
      pbase_d[victim] = ins_pa & ~ins_mask;
      span_d[victim]  = ins_span;
      user_d[victim]  = ins_user;
      wr_d[victim]    = ins_wr;
      glb_d[victim]   = ins_glb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      pbase_q <= '0;
      span_q  <= '0;
      user_q  <= '0;
      wr_q    <= '0;
      glb_q   <= '0;
    end else if (slot_we) begin
      start_q <= start_d;
      pbase_q <= pbase_d;
      span_q  <= span_d;
      user_q  <= user_d;
      wr_q    <= wr_d;
      glb_q   <= glb_d;
    end
  end

  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_op == MNT_FLUSH_ALL) |=> (valid_q == '0)); // R11

  AST_FLUSH_LOCAL_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_op == MNT_FLUSH_LOCAL) |=> ((valid_q & ~glb_q) == '0)); // R11

  AST_INSERT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_do |=> valid_q[$past(victim)]); // R8

  AST_MAINT_BLOCKS_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_busy && ins_en) |=> ($countones(valid_q) <= $past($countones(valid_q)))); // R12

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> !(lk_fault || lk_fault_wr || lk_fault_user || (lk_pa != '0))); // R7

endmodule

// File: tb/xlate_buf_bench.sv
module xlate_buf_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int AW         = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] lk_va, ins_va, ins_pa, mnt_va;
  logic [1:0]    lk_mode, lk_cpl, ins_span, mnt_op;
  logic          lk_force_sup, lk_store_chk, lk_promote;
  logic          ins_en, ins_user, ins_wr, ins_glb;
  logic          lk_hit, lk_fault, lk_fault_wr, lk_fault_user;
  logic [AW-1:0] lk_pa;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_buf #(.ENTRIES(N), .ADDR_W(AW)) u_xlate_buf (
    .clk(clk), .rst_n(rst_n),
    .lk_va(lk_va), .lk_mode(lk_mode), .lk_cpl(lk_cpl),
    .lk_force_sup(lk_force_sup), .lk_store_chk(lk_store_chk),
    .lk_promote(lk_promote),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_fault(lk_fault),
    .lk_fault_wr(lk_fault_wr), .lk_fault_user(lk_fault_user),
    .ins_en(ins_en), .ins_va(ins_va), .ins_pa(ins_pa), .ins_span(ins_span),
    .ins_user(ins_user), .ins_wr(ins_wr), .ins_glb(ins_glb),
    .mnt_op(mnt_op), .mnt_va(mnt_va)
  );

  // Reference model: queue ordered most recent first.
  typedef struct {
    longint base;
    longint pb;
    longint sz;
    bit     u;
    bit     w;
    bit     g;
  } ent_t;

  ent_t   mq[$];
  int     checks = 0;
  int     fails  = 0;
  bit     done   = 0;

  function automatic longint span_bytes(input logic [1:0] c);
    case (c)
      2'd1:    return 64'h20_0000;
      2'd2:    return 64'h4000_0000;
      default: return 64'h1000;
    endcase
  endfunction

  function automatic int find(input longint va);
    for (int i = 0; i < mq.size(); i++)
      if (mq[i].base <= va && mq[i].base + mq[i].sz > va) return i;
    return -1;
  endfunction

  task automatic idle();
    ins_en = 0; mnt_op = 2'b00; lk_promote = 0;
  endtask

  task automatic tick(input string tag);
    int     k;
    bit     eh, ef, ewr, eus, isu, wl;
    longint epa;
    ent_t   e;
    #1;
    k   = find(longint'(lk_va));
    eh  = (k >= 0);
    epa = 0; ef = 0; ewr = 0; eus = 0;
    if (eh && rst_n) begin
      epa = mq[k].pb | (longint'(lk_va) & (mq[k].sz - 1));
      isu = (lk_cpl == 2'd3) && !lk_force_sup;
      wl  = (lk_mode == 2'b01) || lk_store_chk;
      ef  = (isu && !mq[k].u) || (wl && !mq[k].w);
      ewr = ef && wl;
      eus = ef && isu;
    end
    if (!rst_n) eh = 0;
    checks++;
    if (lk_hit !== eh || lk_pa !== AW'(epa) || lk_fault !== ef ||
        lk_fault_wr !== ewr || lk_fault_user !== eus) begin
      fails++;
      $display("FAIL %s va=%h actual hit=%0b pa=%h f=%0b fw=%0b fu=%0b expected hit=%0b pa=%h f=%0b fw=%0b fu=%0b",
               tag, lk_va, lk_hit, lk_pa, lk_fault, lk_fault_wr, lk_fault_user,
               eh, AW'(epa), ef, ewr, eus);
    end
    // Model next state (R11, R12 priority)
    if (rst_n) begin
      if (mnt_op == 2'b01) mq.delete();
      else if (mnt_op == 2'b10) begin
        for (int i = mq.size() - 1; i >= 0; i--) if (!mq[i].g) mq.delete(i);
      end else if (mnt_op == 2'b11) begin
        k = find(longint'(mnt_va));
        if (k >= 0) mq.delete(k);
      end else if (ins_en) begin
        e.sz = span_bytes(ins_span);
        e.base = longint'(ins_va) & ~(e.sz - 1);
        e.pb   = longint'(ins_pa) & ~(e.sz - 1);
        e.u = ins_user; e.w = ins_wr; e.g = ins_glb;
        if (mq.size() == N) void'(mq.pop_back());
        mq.push_front(e);
      end else if (lk_promote && eh) begin
        e = mq[k];
        mq.delete(k);
        mq.push_front(e);
      end
    end
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic put(input logic [AW-1:0] va, input logic [AW-1:0] pa,
                     input logic [1:0] sp, input bit u, input bit w, input bit g);
    ins_en = 1; ins_va = va; ins_pa = pa; ins_span = sp;
    ins_user = u; ins_wr = w; ins_glb = g;
  endtask

  task automatic look(input logic [AW-1:0] va, input logic [1:0] md,
                      input logic [1:0] cpl, input bit fs, input bit sc, input bit pr);
    lk_va = va; lk_mode = md; lk_cpl = cpl; lk_force_sup = fs;
    lk_store_chk = sc; lk_promote = pr;
  endtask

  function automatic logic [AW-1:0] pool_va(input int i);
    if (i < 16) return AW'(32'h0001_0000 + i * 32'h1000 + 32'h10);
    if (i < 20) return AW'(32'h0200_0000 + (i - 16) * 32'h20_0000 + 32'h1_2340);
    return AW'(32'hC000_0000 + 32'h0123_4567);
  endfunction

  function automatic logic [1:0] pool_sp(input int i);
    if (i < 16) return 2'd0;
    if (i < 20) return 2'd1;
    return 2'd2;
  endfunction

  task automatic sweep(input string tag);
    for (int i = 0; i < 21; i++) begin
      look(pool_va(i), 2'b00, 2'd0, 0, 0, 0);
      tick(tag);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin : main
    rst_n = 0;
    idle();
    ins_va = '0; ins_pa = '0; ins_span = '0; ins_user = 0; ins_wr = 0; ins_glb = 0;
    mnt_va = '0;
    look(32'h0000_1234, 2'b00, 2'd3, 0, 0, 0);
    @(negedge clk);
    tick("R1 reset miss");
    rst_n = 1;
    tick("R1 after reset");

    // R1 R2 basic 4 KiB
    put(32'h0000_1000, 32'h8000_0000, 2'd0, 1, 1, 0);
    tick("R13 insert");
    look(32'h0000_1234, 2'b00, 2'd3, 0, 0, 0); tick("R2 pa 4K");
    look(32'h0000_0FFF, 2'b00, 2'd3, 0, 0, 0); tick("R1 below start");
    look(32'h0000_2000, 2'b00, 2'd3, 0, 0, 0); tick("R1 at end");

    // R3 2 MiB, non-user, read-only, global
    put(32'h0040_0000, 32'h1000_0000, 2'd1, 0, 0, 1); tick("R3 insert 2M");
    look(32'h0040_0000, 2'b00, 2'd0, 0, 0, 0); tick("R3 2M start");
    look(32'h005F_FFFF, 2'b00, 2'd0, 0, 0, 0); tick("R3 2M last");
    look(32'h0060_0000, 2'b00, 2'd0, 0, 0, 0); tick("R3 2M end miss");

    // R3 1 GiB with unaligned insert address, top of space
    put(32'hC000_0123, 32'h4000_0456, 2'd2, 1, 0, 0); tick("R3 insert 1G");
    look(32'hFFFF_FFFF, 2'b00, 2'd3, 0, 0, 0); tick("R1 R3 top of space");
    look(32'hC000_0000, 2'b00, 2'd3, 0, 0, 0); tick("R3 masked start");

    // Span code 3 acts as 4 KiB
    put(32'h0000_8000, 32'h0009_0000, 2'd3, 1, 1, 0); tick("R3 code3");
    look(32'h0000_8FFF, 2'b00, 2'd0, 0, 0, 0); tick("R3 code3 last");
    look(32'h0000_9000, 2'b00, 2'd0, 0, 0, 0); tick("R3 code3 end");

    // Permissions on the 2M slot (non-user, read-only)
    look(32'h0040_0010, 2'b00, 2'd3, 0, 0, 0); tick("R4 user fault");
    look(32'h0040_0010, 2'b00, 2'd3, 1, 0, 0); tick("R4 force sup");
    look(32'h0040_0010, 2'b00, 2'd2, 0, 0, 0); tick("R4 cpl2 sup");
    look(32'h0040_0010, 2'b01, 2'd0, 0, 0, 0); tick("R5 write ro");
    look(32'h0040_0010, 2'b10, 2'd0, 0, 0, 0); tick("R5 exec ro");
    look(32'h0040_0010, 2'b00, 2'd0, 0, 1, 0); tick("R6 store check");
    look(32'h0040_0010, 2'b01, 2'd3, 0, 0, 0); tick("R4 R5 both");
    look(32'h0000_1010, 2'b01, 2'd3, 0, 1, 0); tick("R5 R6 writable ok");
    look(32'h7000_0000, 2'b01, 2'd3, 0, 1, 0); tick("R7 miss quiet");

    // Fill and evict (R8 R9 R10)
    mq.delete();
    mnt_op = 2'b01; tick("R11 flush all");
    sweep("R11 empty");
    for (int i = 0; i < N; i++) begin
      put(pool_va(i), 32'h2000_0000 + i * 32'h1000, 2'd0, 1, 1, i[0]);
      tick("R8 fill");
    end
    sweep("R8 all kept");
    look(pool_va(0), 2'b00, 2'd0, 0, 0, 1); tick("R9 promote");
    look(pool_va(1), 2'b00, 2'd0, 0, 0, 0); tick("R10 no promote");
    mnt_va = pool_va(7); look(pool_va(2), 2'b00, 2'd0, 0, 0, 0); tick("R10 lookup");
    put(pool_va(8), 32'h3000_0000, 2'd0, 1, 1, 0); tick("R9 evict");
    sweep("R9 victim gone");
    put(pool_va(9), 32'h3100_0000, 2'd0, 1, 1, 0); tick("R9 evict 2");
    sweep("R9 victim 2");

    // Same-cycle collisions (R12)
    put(pool_va(10), 32'h3200_0000, 2'd0, 1, 1, 0);
    look(pool_va(3), 2'b00, 2'd0, 0, 0, 1); tick("R12 insert beats promote");
    put(pool_va(11), 32'h3300_0000, 2'd0, 1, 1, 0); tick("R12 next evict");
    sweep("R12 order");
    mnt_op = 2'b11; mnt_va = pool_va(5);
    look(pool_va(4), 2'b00, 2'd0, 0, 0, 1); tick("R12 demap beats promote");
    put(pool_va(12), 32'h3400_0000, 2'd0, 1, 1, 0); mnt_op = 2'b10;
    tick("R12 flush beats insert");
    sweep("R11 R12 local flush");
    mnt_op = 2'b11; mnt_va = 32'h7777_0000; tick("R11 demap miss");
    sweep("R11 demap miss kept");

    // Random phase
    for (int c = 0; c < 3000; c++) begin
      int r, p;
      r = int'($urandom_range(0, 19));
      p = int'($urandom_range(0, 20));
      look(pool_va(p) ^ AW'($urandom_range(0, 15)), 2'($urandom_range(0, 2)),
           2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if (r < 7) begin
        int q;
        q = int'($urandom_range(0, 20));
        if (find(longint'(pool_va(q))) < 0)
          put(pool_va(q), AW'($urandom) & 32'hFFFF_F000, pool_sp(q),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)));
      end
      if (r == 8)  begin mnt_op = 2'b11; mnt_va = pool_va(int'($urandom_range(0, 20))); end
      if (r == 9)  mnt_op = 2'b10;
      if (r == 10 && c % 7 == 0) mnt_op = 2'b01;
      tick("R9 R10 R12 random");
    end
    sweep("R9 final");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule